// File: doc/BRIEF.md
# Clock Source Enable and System Clock Switch Controller

This block starts and stops three clock sources and chooses which source drives the system clock. The sources are an internal high-speed RC oscillator, an external crystal oscillator and one PLL. A fourth source, a low-power internal oscillator, is always running and always available. Software enables a source through a control register and polls its read-only ready flag. It then writes a switch request code and polls the switch status field until that field shows the requested code. Oscillator start-up and PLL lock are not modelled as analog behaviour. A parameterised settle counter stands in for each of them, and an input pin reports when the external crystal is stable.

The switch is safe against unready sources. A request that names a source whose ready flag is low stays pending, and the status keeps the previous code until that source becomes ready. The PLL takes its input from a selectable reference. One code of that select means "no clock", and with it the PLL never locks. The PLL cannot be turned off while it drives the system clock, or while a pending request names it. The block also reports the frequency of the internal oscillator after its power-of-two divider.

The register port is a plain synchronous one. Writes take effect on the clock edge where the write strobe is high. Reads return data one cycle after the read strobe.

Top module: `clk_src_ctrl`

## Requirements
- R1: After reset the control register reads as internal oscillator enabled (bit 0 = 1) with every other enable, bypass and divider bit 0. The switch request and status are both code 0, the PLL input select is 0 and the reported internal rate equals BASE_KHZ. The ready outputs `src_rdy` (bit 0 internal, bit 1 external, bit 2 PLL) are 0 while reset is held.
- R2: Control register bit positions: internal enable 0, internal ready 2, external enable 16, external ready 17, external bypass 18, PLL enable 24, PLL ready 25. The ready bits are read-only. A source's ready flag rises LAT+1 cycles after its enable condition first holds, where LAT is that source's latency parameter. It falls one cycle after the enable condition drops.
- R3: The external oscillator's enable condition is its enable bit AND the `xtal_ok` input. With `xtal_ok` low the external oscillator never becomes ready.
- R4: Writing zero to the switch register (address 1) requests code 0, the internal high-speed oscillator.
- R5: With the external bypass bit set, the external oscillator becomes ready one cycle after its enable condition holds.
- R6: The internal oscillator divider is control bits 4:3. `int_osc_khz` equals BASE_KHZ shifted right by that value, and it updates one cycle after the write.
- R7: Switch codes: 0 internal high-speed, 1 low-power internal, 2 external, 3 PLL. The request is in switch register bits 2:0 and the status in bits 5:3, and the status also appears on `sys_src`. When the requested source is ready, the status takes the requested code on the next clock edge.
- R8: A request that names a source that is not ready is held pending. The status keeps its old code until the source becomes ready.
- R9: A write of a switch code from 4 to 7 is ignored, and the request and status keep their values.
- R10: The PLL input select is in register address 2, bits 1:0: 0 internal high-speed, 1 low-power internal, 2 external, 3 no clock. The PLL's enable condition is its enable bit AND a ready input reference. With code 3 it never locks.
- R11: A control write that clears the PLL enable is ignored for that bit in two cases: while the status is code 3, or while the request is code 3.
- R12: A read returns the addressed register one cycle after the read strobe. Address 0 is control, 1 is the switch, 2 is the PLL input select, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| xtal_ok | input | 1 | External crystal reports a stable oscillation |
| src_rdy | output | 3 | Ready flags: bit 0 internal, bit 1 external, bit 2 PLL |
| sys_src | output | 3 | Current system clock switch status code |
| int_osc_khz | output | RATE_W | Internal oscillator frequency after the divider, in kHz |

## Verification
The bench builds the block with settle latencies of 3, 5 and 7 cycles for the internal, external and PLL sources, and a base rate of 64000 kHz. These short latencies put the exact ready-rise cycle of every source within reach of a cycle-counting loop. They also allow a sweep of all four PLL reference codes, all four divider codes and all eight switch codes, each ending in a settled state. Pending requests, bypass, the point at which a switch completes and the PLL disable guard are all run against these small counts. The expected values are derived from the latency and rate arithmetic in the requirements.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
  // switch / source codes
  localparam logic [2:0] SW_INT = 3'd0;
  localparam logic [2:0] SW_LP  = 3'd1;
  localparam logic [2:0] SW_EXT = 3'd2;
  localparam logic [2:0] SW_PLL = 3'd3;

  // PLL reference select codes
  localparam logic [1:0] PREF_INT  = 2'd0;
  localparam logic [1:0] PREF_LP   = 2'd1;
  localparam logic [1:0] PREF_EXT  = 2'd2;
  localparam logic [1:0] PREF_NONE = 2'd3;

  // control register bit positions (software decodes these)
  localparam int CB_INT_EN  = 0;
  localparam int CB_INT_RDY = 2;
  localparam int CB_DIV_LO  = 3;
  localparam int CB_EXT_EN  = 16;
  localparam int CB_EXT_RDY = 17;
  localparam int CB_EXT_BYP = 18;
  localparam int CB_PLL_EN  = 24;
  localparam int CB_PLL_RDY = 25;

  // register addresses
  localparam int RA_CTRL = 0;
  localparam int RA_SW   = 1;
  localparam int RA_PREF = 2;

  // ready vector positions
  localparam int RV_INT = 0;
  localparam int RV_EXT = 1;
  localparam int RV_PLL = 2;
  localparam int N_SRC  = 3;
endpackage

// File: rtl/clksw_rdy_timer.sv
`timescale 1ns/1ps
module clksw_rdy_timer #(
  parameter int LAT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic skip,
  output logic rdy
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LAT_C = CW'(LAT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rdy   <= 1'b0;
    end else if (!go) begin
      cnt_q <= '0;
      rdy   <= 1'b0;
    end else begin
      if (cnt_q != LAT_C) cnt_q <= cnt_q + 1'b1;
      rdy <= rdy || skip || (cnt_q == LAT_C);
    end
  end

  // R2: ready drops right after the enable condition goes away
  p_fall_after_off_r2: assert property (@(posedge clk) disable iff (rst)
    !go |=> !rdy);

  // R2 / R5: a rise needs a full settle count or bypass
  p_rise_settled_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> ($past(go) && ($past(cnt_q) == LAT_C || $past(skip))));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAT_C);
endmodule

// File: rtl/clksw_switch.sv
`timescale 1ns/1ps
module clksw_switch (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] req,
  input  logic [3:0] avail,
  output logic [2:0] stat_q
);
  import clksw_pkg::*;

  logic target_ok;
  logic hop;

  assign target_ok = !req[2] && avail[req[1:0]];
  assign hop       = (req != stat_q) && target_ok;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= SW_INT;
    else if (hop) stat_q <= req;
  end

  // R7: a ready target is taken on the next edge
  p_switch_done_r7: assert property (@(posedge clk) disable iff (rst)
    (req != stat_q && avail[req[1:0]]) |=> (stat_q == $past(req)));

  // R8: an unready target leaves the status alone
  p_pending_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !avail[req[1:0]] |=> $stable(stat_q));

  // R9: status never carries a reserved code
  p_status_legal_r9: assert property (@(posedge clk) disable iff (rst)
    !stat_q[2]);
endmodule

// File: rtl/clksw_regfile.sv
`timescale 1ns/1ps
module clksw_regfile #(
  parameter int AW       = 2,
  parameter int DW       = 32,
  parameter int RATE_W   = 32,
  parameter int BASE_KHZ = 64000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [2:0]        rdy,
  input  logic [2:0]        stat,
  output logic              int_en,
  output logic              ext_en,
  output logic              ext_byp,
  output logic              pll_en,
  output logic [2:0]        req,
  output logic [1:0]        pref,
  output logic [RATE_W-1:0] rate
);
  import clksw_pkg::*;

  localparam logic [RATE_W-1:0] BASE_C = RATE_W'(BASE_KHZ);

  logic [1:0]    div_q;
  logic          pll_locked_in;
  logic          wr_ctrl, wr_sw, wr_pref;
  logic [DW-1:0] ctrl_view, sw_view, pref_view, rd_mux;
  logic          unused_wdata;

  assign unused_wdata  = ^wdata;
  assign wr_ctrl       = wr && (addr == AW'(RA_CTRL));
  assign wr_sw         = wr && (addr == AW'(RA_SW));
  assign wr_pref       = wr && (addr == AW'(RA_PREF));
  assign pll_locked_in = (stat == SW_PLL) || (req == SW_PLL);

  always_ff @(posedge clk) begin
    if (rst) begin
      int_en  <= 1'b1;
      div_q   <= 2'd0;
      ext_en  <= 1'b0;
      ext_byp <= 1'b0;
      pll_en  <= 1'b0;
      req     <= SW_INT;
      pref    <= PREF_INT;
      rate    <= BASE_C;
    end else begin
      if (wr_ctrl) begin
        int_en  <= wdata[CB_INT_EN];
        div_q   <= wdata[CB_DIV_LO +: 2];
        ext_en  <= wdata[CB_EXT_EN];
        ext_byp <= wdata[CB_EXT_BYP];
        if (wdata[CB_PLL_EN] || !pll_locked_in) pll_en <= wdata[CB_PLL_EN];
        rate    <= BASE_C >> wdata[CB_DIV_LO +: 2];
      end
      if (wr_sw && !wdata[2]) req <= wdata[2:0];
      if (wr_pref) pref <= wdata[1:0];
    end
  end

  always_comb begin
    ctrl_view                  = '0;
    ctrl_view[CB_INT_EN]       = int_en;
    ctrl_view[CB_INT_RDY]      = rdy[RV_INT];
    ctrl_view[CB_DIV_LO +: 2]  = div_q;
    ctrl_view[CB_EXT_EN]       = ext_en;
    ctrl_view[CB_EXT_RDY]      = rdy[RV_EXT];
    ctrl_view[CB_EXT_BYP]      = ext_byp;
    ctrl_view[CB_PLL_EN]       = pll_en;
    ctrl_view[CB_PLL_RDY]      = rdy[RV_PLL];
    sw_view                    = '0;
    sw_view[2:0]               = req;
    sw_view[5:3]               = stat;
    pref_view                  = '0;
    pref_view[1:0]             = pref;
    case (addr)
      AW'(RA_CTRL): rd_mux = ctrl_view;
      AW'(RA_SW):   rd_mux = sw_view;
      AW'(RA_PREF): rd_mux = pref_view;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R11: the PLL stays enabled while it is the system clock
  p_pll_guard_r11: assert property (@(posedge clk) disable iff (rst)
    (stat == SW_PLL) |-> pll_en);

  // R9: reserved codes never reach the request
  p_req_legal_r9: assert property (@(posedge clk) disable iff (rst)
    !req[2]);

  // R4: a zero write selects the internal oscillator
  p_zero_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_sw && wdata[2:0] == 3'd0) |=> (req == SW_INT));

  // R6: rate only moves after a control write
  p_rate_on_write_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(rate));
endmodule

// File: rtl/clk_src_ctrl.sv
`timescale 1ns/1ps
module clk_src_ctrl #(
  parameter int AW       = 2,
  parameter int DW       = 32,
  parameter int RATE_W   = 32,
  parameter int BASE_KHZ = 64000,
  parameter int INT_LAT  = 16,
  parameter int EXT_LAT  = 64,
  parameter int PLL_LAT  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              xtal_ok,
  output logic [2:0]        src_rdy,
  output logic [2:0]        sys_src,
  output logic [RATE_W-1:0] int_osc_khz
);
  import clksw_pkg::*;

  logic             int_en, ext_en, ext_byp, pll_en;
  logic [2:0]       req;
  logic [1:0]       pref;
  logic             pref_ok;
  logic [N_SRC-1:0] go_v, skip_v, rdy_v;
  logic [3:0]       avail;

  clksw_regfile #(
    .AW(AW), .DW(DW), .RATE_W(RATE_W), .BASE_KHZ(BASE_KHZ)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .rdy(rdy_v), .stat(sys_src),
    .int_en(int_en), .ext_en(ext_en), .ext_byp(ext_byp), .pll_en(pll_en),
    .req(req), .pref(pref), .rate(int_osc_khz)
  );

  always_comb begin
    case (pref)
      PREF_INT: pref_ok = rdy_v[RV_INT];
      PREF_LP:  pref_ok = 1'b1;
      PREF_EXT: pref_ok = rdy_v[RV_EXT];
      default:  pref_ok = 1'b0;
    endcase
  end

  assign go_v[RV_INT]   = int_en;
  assign go_v[RV_EXT]   = ext_en && xtal_ok;
  assign go_v[RV_PLL]   = pll_en && pref_ok;
  assign skip_v[RV_INT] = 1'b0;
  assign skip_v[RV_EXT] = ext_byp;
  assign skip_v[RV_PLL] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    localparam int L = (g == RV_INT) ? INT_LAT : (g == RV_EXT) ? EXT_LAT : PLL_LAT;
    clksw_rdy_timer #(.LAT(L)) u_tmr (
      .clk(clk), .rst(rst), .go(go_v[g]), .skip(skip_v[g]), .rdy(rdy_v[g])
    );
  end

  assign avail   = {rdy_v[RV_PLL], rdy_v[RV_EXT], 1'b1, rdy_v[RV_INT]};
  assign src_rdy = rdy_v;

  clksw_switch u_sw (
    .clk(clk), .rst(rst), .req(req), .avail(avail), .stat_q(sys_src)
  );

  // R10: the PLL cannot be ready on the no-clock reference
  p_no_ref_no_lock_r10: assert property (@(posedge clk) disable iff (rst)
    (pref == PREF_NONE) |=> !src_rdy[RV_PLL]);

  // R3: the crystal must report stable before the external flag can be set
  p_xtal_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !xtal_ok |=> !src_rdy[RV_EXT]);
endmodule

// File: tb/clk_src_ctrl_bench.sv
`timescale 1ns/1ps
module clk_src_ctrl_bench;
  localparam int INT_LAT = 3;
  localparam int EXT_LAT = 5;
  localparam int PLL_LAT = 7;
  localparam int BASE    = 64000;

  logic        clk = 1'b0;
  logic        rst, reg_wr, reg_rd, xtal_ok;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, int_osc_khz;
  logic [2:0]  src_rdy, sys_src;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  clk_src_ctrl #(
    .BASE_KHZ(BASE), .INT_LAT(INT_LAT), .EXT_LAT(EXT_LAT), .PLL_LAT(PLL_LAT)
  ) u_clk_src_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xtal_ok(xtal_ok),
    .src_rdy(src_rdy), .sys_src(sys_src), .int_osc_khz(int_osc_khz)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // negedges until ready bit b first seen high; 0 when never within maxn
  task automatic rise_at(input int b, input int maxn, output int n);
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk);
      if (src_rdy[b] && n == 0) n = i;
    end
  endtask

  task automatic wrap_up;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    wrap_up();
  end

  initial begin
    logic [31:0] d, ctl;
    int n, nr, ns;
    rst = 1'b1; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; xtal_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready flags in reset", {29'd0, src_rdy}, 32'd0);
    chk("R1 status in reset", {29'd0, sys_src}, 32'd0);
    chk("R1 rate in reset", int_osc_khz, BASE);
    rst = 1'b0;
    rise_at(0, 10, n);
    chk("R2 internal ready latency", n, INT_LAT + 1);

    rd(2'd0, d); chk("R1 R12 control readback", d, 32'h5);
    rd(2'd1, d); chk("R1 R12 switch readback", d, 32'h0);
    rd(2'd2, d); chk("R1 R12 pll select readback", d, 32'h0);
    rd(2'd3, d); chk("R12 unused address", d, 32'h0);

    // R6 divider sweep
    for (int dv = 0; dv < 4; dv++) begin
      ctl = 32'h1 | (32'(dv) << 3);
      wr(2'd0, ctl);
      chk("R6 divided rate", int_osc_khz, BASE >> dv);
      rd(2'd0, d); chk("R6 divider readback", d, ctl | 32'h4);
    end
    ctl = 32'h1;
    wr(2'd0, ctl);

    // R3 external without stable crystal, R8 pending switch
    ctl |= 32'h1 << 16;
    wr(2'd0, ctl);
    repeat (20) @(negedge clk);
    chk("R3 no ready without crystal", {31'd0, src_rdy[1]}, 0);
    wr(2'd1, 32'd2);
    repeat (3) @(negedge clk);
    chk("R8 status holds while pending", {29'd0, sys_src}, 0);
    rd(2'd1, d); chk("R8 request pending readback", d, 32'h02);

    // R2 R7 crystal settles, switch follows one cycle later
    xtal_ok = 1'b1;
    nr = 0; ns = 0;
    for (int i = 1; i <= 15; i++) begin
      @(negedge clk);
      if (src_rdy[1] && nr == 0) nr = i;
      if (sys_src == 3'd2 && ns == 0) ns = i;
    end
    chk("R2 external ready latency", nr, EXT_LAT + 1);
    chk("R7 switch one cycle after ready", ns, EXT_LAT + 2);
    rd(2'd1, d); chk("R7 status field", d, 32'h12);

    // R4 zero write returns to internal
    wr(2'd1, 32'd0);
    chk("R7 status before completion edge", {29'd0, sys_src}, 2);
    @(negedge clk);
    chk("R4 zero write selects internal", {29'd0, sys_src}, 0);

    // R2 falling edge
    ctl &= ~(32'h1 << 16);
    wr(2'd0, ctl);
    chk("R2 ready still set at write edge", {31'd0, src_rdy[1]}, 1);
    @(negedge clk);
    chk("R2 ready falls one cycle later", {31'd0, src_rdy[1]}, 0);

    // R5 bypass
    ctl |= (32'h1 << 16) | (32'h1 << 18);
    wr(2'd0, ctl);
    chk("R5 bypass not yet ready", {31'd0, src_rdy[1]}, 0);
    @(negedge clk);
    chk("R5 bypass ready next cycle", {31'd0, src_rdy[1]}, 1);

    // R7 low-power source is always ready
    wr(2'd1, 32'd1);
    @(negedge clk);
    chk("R7 switch to low-power", {29'd0, sys_src}, 1);

    // R9 reserved codes
    for (int c = 4; c < 8; c++) begin
      wr(2'd1, 32'(c));
      @(negedge clk);
      chk("R9 reserved code status", {29'd0, sys_src}, 1);
      rd(2'd1, d); chk("R9 reserved code readback", d, 32'h09);
    end
    wr(2'd1, 32'd0);
    @(negedge clk);

    // R10 PLL reference sweep
    for (int s = 0; s < 4; s++) begin
      wr(2'd2, 32'(s));
      rd(2'd2, d); chk("R10 R12 reference readback", d, 32'(s));
      wr(2'd0, ctl | (32'h1 << 24));
      rise_at(2, 15, n);
      chk("R10 pll lock latency", n, (s < 3) ? PLL_LAT + 1 : 0);
      wr(2'd0, ctl);
      @(negedge clk);
      chk("R10 pll off after disable", {31'd0, src_rdy[2]}, 0);
    end

    // R11 guard while PLL is the system clock
    wr(2'd2, 32'd2);
    ctl |= 32'h1 << 24;
    wr(2'd0, ctl);
    repeat (10) @(negedge clk);
    wr(2'd1, 32'd3);
    @(negedge clk);
    chk("R7 switch to pll", {29'd0, sys_src}, 3);
    wr(2'd0, ctl & ~(32'h1 << 24));
    repeat (3) @(negedge clk);
    chk("R11 pll stays ready", {31'd0, src_rdy[2]}, 1);
    rd(2'd0, d); chk("R11 pll enable kept", d, 32'h03070005);
    wr(2'd1, 32'd0);
    @(negedge clk);
    chk("R4 leave pll", {29'd0, sys_src}, 0);
    ctl &= ~(32'h1 << 24);
    wr(2'd0, ctl);
    @(negedge clk);
    chk("R11 pll disable allowed when unused", {31'd0, src_rdy[2]}, 0);
    wr(2'd1, 32'd3);
    repeat (5) @(negedge clk);
    chk("R8 pending on stopped pll", {29'd0, sys_src}, 0);
    rd(2'd1, d); chk("R8 pending pll readback", d, 32'h03);

    wrap_up();
  end
endmodule